// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This block drives the dynamic phase-adjust port of a clock synthesizer. It handles one phase adjustment at a time. User logic raises a request for one cycle and gives a direction bit and a counter-select value. The sequencer then raises the step strobe and holds it for a fixed number of scan-clock cycles. It keeps the direction and counter-select lines steady while the synthesizer captures them. Finally it waits for the completion handshake: the return line goes low, then comes back high.

All outputs change only on rising scan-clock edges, because the synthesizer samples the strobe on falling edges. The completion low pulse can be shorter than one scan-clock period. A falling-edge catcher therefore records that the pulse happened even when no rising edge falls inside it.

A wait timer bounds the handshake. If the return line never falls, or never rises again, the sequencer gives up after a set number of cycles, raises an error pulse and returns to idle.

Top module: `pll_phase_stepper`

## Requirements
- R1: While `rst` is high and after it falls, `busy_o`, `done_o`, `err_o` and `phase_step_o` are 0, and `phase_dir_o` and `phase_sel_o` are all zeros.
- R2: A request sampled in idle, with `phase_done_i` high, raises `phase_step_o` and `busy_o` in the next cycle. `phase_step_o` stays high for exactly `STEP_CYC` (default 2) cycles.
- R3: From the cycle the strobe rises until the cycle the sequence ends, `phase_dir_o` and `phase_sel_o` carry the requested values and do not change. At the second rising edge after the strobe is first seen on a falling edge, they equal the request. Whenever the block is idle, they are zero.
- R4: A low pulse on `phase_done_i` of any width, including less than one cycle, is recognised. After the line is high again, `done_o` pulses for one cycle, and `busy_o` is 0 in that same cycle.
- R5: A request that arrives while `busy_o` is high has no effect: the controls keep the first request's values, and no second sequence or completion follows.
- R6: A request in idle while `phase_done_i` is low is ignored: `busy_o` and `phase_step_o` stay 0.
- R7: If the handshake does not complete within `TMO_CYC` cycles of waiting, `err_o` pulses for one cycle and the block returns to idle. The pulse comes `TMO_CYC + 3` cycles after the strobe rises, whether the return line never fell or never rose again.
- R8: `done_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle request for a phase step |
| dir_i | input | 1 | Requested direction (1 = up, 0 = down) |
| sel_i | input | SEL_W | Requested counter select |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse: step completed |
| err_o | output | 1 | One-cycle pulse: handshake timed out |
| phase_step_o | output | 1 | Step strobe to the synthesizer |
| phase_dir_o | output | 1 | Direction line to the synthesizer |
| phase_sel_o | output | SEL_W | Counter-select bus to the synthesizer |
| phase_done_i | input | 1 | Completion return line, low while shifting |

## Verification
A wrong sequencer state shows at the pins within one cycle. A stuck or early state changes the strobe width, and the bench's model of the synthesizer measures that width on the first falling edge it can. A lost capture in the edge catcher does not show at once. It appears `TMO_CYC` cycles later, as an error pulse where a done pulse was expected, so the scoreboard reports it at that completion. A corrupted control register shows as a captured direction or select that does not match the request, and the scoreboard reports it at the next completion.

// File: rtl/pds_pkg.sv
package pds_pkg;

    // Sequencer states; the encoding of ST_IDLE must be zero.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STEP  = 3'd1,
        ST_CAPT  = 3'd2,
        ST_WLOW  = 3'd3,
        ST_WHIGH = 3'd4
    } pds_state_e;

endpackage

// File: rtl/pds_fall_catch.sv
// Records a falling edge of the completion line, even one whose low time
// is shorter than a clock period. Asynchronous set on the falling edge,
// synchronous clear whenever the sequencer is idle or in reset.
module pds_fall_catch (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic line_i,
    output logic seen_o
);

    logic seen_q;

    always_ff @(posedge clk or negedge line_i) begin
        if (!line_i) begin
            seen_q <= 1'b1;
        end else if (rst || !arm_i) begin
            seen_q <= 1'b0;
        end
    end

    assign seen_o = seen_q;

endmodule

// File: rtl/pds_wait_timer.sv
// Saturating wait counter: runs while run_i is high, clears otherwise.
module pds_wait_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);

    localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == LAST);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run_i && expired_o) |=> (!run_i || expired_o)); // R7

    AST_TMR_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/pll_phase_stepper.sv
module pll_phase_stepper #(
    parameter int SEL_W    = 4,
    parameter int STEP_CYC = 2,
    parameter int TMO_CYC  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             dir_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             phase_step_o,
    output logic             phase_dir_o,
    output logic [SEL_W-1:0] phase_sel_o,
    input  logic             phase_done_i
);

    import pds_pkg::*;

    localparam int SCW = $clog2(STEP_CYC + 1);
    localparam logic [SCW-1:0] STEP_LAST = SCW'(STEP_CYC - 1);

    typedef struct packed {
        pds_state_e       st;
        logic [SCW-1:0]   scnt;
        logic             dir;
        logic [SEL_W-1:0] sel;
        logic             done;
        logic             err;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:   ST_IDLE,
        scnt: '0,
        dir:  1'b0,
        sel:  '0,
        done: 1'b0,
        err:  1'b0
    };

    regs_t r_d, r_q;
    logic  armed;
    logic  waiting;
    logic  fell_seen;
    logic  tmo_hit;

    assign armed   = (r_q.st != ST_IDLE);
    assign waiting = (r_q.st == ST_WLOW) || (r_q.st == ST_WHIGH);

    pds_fall_catch i_catch (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (armed),
        .line_i (phase_done_i),
        .seen_o (fell_seen)
    );

    pds_wait_timer #(
        .LIMIT (TMO_CYC)
    ) i_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (waiting),
        .expired_o (tmo_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i && phase_done_i) begin
                    r_d.st   = ST_STEP;
                    r_d.scnt = '0;
                    r_d.dir  = dir_i;
                    r_d.sel  = sel_i;
                end
            end
            ST_STEP: begin
                if (r_q.scnt == STEP_LAST) begin
                    r_d.st = ST_CAPT;
                end else begin
                    r_d.scnt = r_q.scnt + 1'b1;
                end
            end
            ST_CAPT: begin
                r_d.st = ST_WLOW;
            end
            ST_WLOW: begin
                if (fell_seen) begin
                    r_d.st = ST_WHIGH;
                end else if (tmo_hit) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                    r_d.dir = 1'b0;
                    r_d.sel = '0;
                end
            end
            ST_WHIGH: begin
                if (phase_done_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.dir  = 1'b0;
                    r_d.sel  = '0;
                end else if (tmo_hit) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                    r_d.dir = 1'b0;
                    r_d.sel = '0;
                end
            end
            default: begin
                r_d = REGS_RST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = armed;
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;
    assign phase_step_o = (r_q.st == ST_STEP);
    assign phase_dir_o  = r_q.dir;
    assign phase_sel_o  = r_q.sel;

    AST_STEP_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_step_o) |=> phase_step_o); // R2

    AST_STEP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        phase_step_o |-> busy_o); // R2

    AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ($stable(phase_dir_o) && $stable(phase_sel_o))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!phase_step_o && !phase_dir_o && phase_sel_o == '0)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R4

    AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o) |-> !busy_o); // R4

    AST_START_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(phase_done_i) && $past(req_i))); // R6

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o); // R7

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o)); // R8

endmodule

// File: tb/test_pll_phase_stepper.sv
`timescale 1ns/1ps
module test_pll_phase_stepper;

    localparam int SEL_W    = 4;
    localparam int STEP_CYC = 2;
    localparam int TMO      = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req = 1'b0;
    logic             dir = 1'b0;
    logic [SEL_W-1:0] sel = '0;
    logic             busy, done, err, pstep, pdir;
    logic [SEL_W-1:0] psel;
    logic             done_line = 1'b1;

    always #10 clk = ~clk;   // 50 MHz

    pll_phase_stepper #(
        .SEL_W    (SEL_W),
        .STEP_CYC (STEP_CYC),
        .TMO_CYC  (TMO)
    ) i_pll_phase_stepper (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .dir_i        (dir),
        .sel_i        (sel),
        .busy_o       (busy),
        .done_o       (done),
        .err_o        (err),
        .phase_step_o (pstep),
        .phase_dir_o  (pdir),
        .phase_sel_o  (psel),
        .phase_done_i (done_line)
    );

    typedef struct {
        bit             is_err;
        bit             d;
        logic [SEL_W-1:0] s;
    } exp_t;

    typedef struct {
        bit             d;
        logic [SEL_W-1:0] s;
    } cap_t;

    exp_t exp_q[$];
    cap_t cap_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   pll_mode = 0;   // 0 normal, 1 never falls, 2 stays low
    int   low_ns   = 5;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
        end
    endtask

    // Model of the synthesizer's phase port.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && pstep) begin
                @(posedge clk);
                @(negedge clk);
                chk(pstep === 1'b1, "R2", "strobe second cycle", int'(pstep), 1);
                @(posedge clk);
                begin
                    cap_t c;
                    c.d = pdir;
                    c.s = psel;
                    if (pll_mode == 0) cap_q.push_back(c);
                end
                if (pll_mode != 1) begin
                    fork
                        begin
                            int w;
                            int m;
                            w = low_ns;
                            m = pll_mode;
                            #1 done_line = 1'b0;
                            if (m == 0) begin
                                #(w) done_line = 1'b1;
                            end
                        end
                    join_none
                end
                @(negedge clk);
                chk(pstep === 1'b0, "R2", "strobe dropped after width", int'(pstep), 0);
                wait (busy === 1'b0);
            end
        end
    end

    // Scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (done || err)) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "completion with nothing pending", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(err == e.is_err, "R7", "error flag at completion", int'(err), int'(e.is_err));
                    chk(done == !e.is_err, "R4", "done flag at completion", int'(done), int'(!e.is_err));
                    if (!e.is_err) begin
                        if (cap_q.size() == 0) begin
                            chk(1'b0, "R3", "no capture recorded", 0, 1);
                        end else begin
                            cap_t c;
                            c = cap_q.pop_front();
                            chk(c.d == e.d, "R3", "captured direction", int'(c.d), int'(e.d));
                            chk(c.s == e.s, "R3", "captured select", int'(c.s), int'(e.s));
                        end
                    end
                    chk(busy == 1'b0, "R4", "busy at completion", int'(busy), 0);
                    chk(pdir == 1'b0 && psel == '0, "R3", "controls zero at completion",
                        int'(psel), 0);
                end
            end
        end
    end

    task automatic issue(input bit d, input logic [SEL_W-1:0] s);
        @(negedge clk);
        req = 1'b1;
        dir = d;
        sel = s;
        @(negedge clk);
        req = 1'b0;
        chk(pstep == 1'b1, "R2", "strobe one cycle after request", int'(pstep), 1);
        chk(busy == 1'b1, "R2", "busy one cycle after request", int'(busy), 1);
    endtask

    task automatic push_exp(input bit is_err, input bit d, input logic [SEL_W-1:0] s);
        exp_t e;
        e.is_err = is_err;
        e.d = d;
        e.s = s;
        exp_q.push_back(e);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R5", "no further sequence after end", int'(busy), 0);
    endtask

    task automatic run_ok(input bit d, input logic [SEL_W-1:0] s, input int w);
        pll_mode = 0;
        low_ns = w;
        push_exp(1'b0, d, s);
        issue(d, s);
        wait_idle();
    endtask

    task automatic run_tmo(input bit d, input logic [SEL_W-1:0] s, input int mode);
        int n;
        pll_mode = mode;
        push_exp(1'b1, d, s);
        issue(d, s);
        n = 0;
        while (!err && n < 10 * TMO) begin
            @(negedge clk);
            n++;
        end
        chk(n == TMO + 3, "R7", "timeout latency from strobe rise", n, TMO + 3);
        while (busy) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R4", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0 && pstep == 0, "R1", "flags in reset",
            int'({busy, done, err, pstep}), 0);
        chk(pdir == 0 && psel == '0, "R1", "controls in reset", int'(psel), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && pstep == 0 && psel == '0, "R1", "state after reset",
            int'({busy, pstep}), 0);

        // R4: completion pulse shorter than a cycle, longer, and about one cycle
        run_ok(1'b1, 4'd5, 5);
        run_ok(1'b0, 4'd10, 70);
        run_ok(1'b1, 4'd9, 25);

        // R5: second request while busy is ignored
        pll_mode = 0;
        low_ns = 30;
        push_exp(1'b0, 1'b1, 4'd3);
        issue(1'b1, 4'd3);
        req = 1'b1;
        dir = 1'b0;
        sel = 4'd12;
        @(negedge clk);
        req = 1'b0;
        chk(pdir == 1'b1 && psel == 4'd3, "R5", "controls kept during busy request",
            int'(psel), 3);
        wait_idle();

        // R7: completion line never falls
        run_tmo(1'b1, 4'd7, 1);
        wait_idle();

        // R7: completion line falls and stays low
        run_tmo(1'b0, 4'd6, 2);
        chk(done_line == 1'b0, "R6", "line still low for next test", int'(done_line), 0);

        // R6: request while the line is low is ignored
        @(negedge clk);
        req = 1'b1;
        dir = 1'b1;
        sel = 4'd11;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b0, "R6", "busy after request with line low", int'(busy), 0);
        chk(pstep == 1'b0, "R6", "strobe after request with line low", int'(pstep), 0);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && psel == '0, "R6", "still idle", int'(psel), 0);
        done_line = 1'b1;
        repeat (2) @(negedge clk);

        // recovery after faults
        run_ok(1'b0, 4'd15, 3);

        chk(exp_q.size() == 0, "R4", "pending expectations at end", exp_q.size(), 0);
        chk(cap_q.size() == 0, "R3", "unmatched captures at end", cap_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule